// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Sender

This block holds a pair of memory-mapped command words that software uses to build and launch an inter-processor interrupt message. Software first writes a destination word, which carries the target unit's identifier. It then writes a command word, which carries the vector, the delivery mode, the trigger and level selections and a destination shorthand. The command write launches the message on an outbound valid/ready port.

While a message waits for the outbound handshake, a status bit in the command word reads as one, and software polls that bit before it builds the next message. Command writes that arrive during that time are dropped. Writes to the destination word still land, but they cannot change the message that is already in flight. When the shorthand selects every unit, the outbound destination is forced to all ones, whatever the destination word holds. The block only formats and hands off messages. It does no arbitration and no receiving, and it takes no processor reset or startup action.

Top module: `ipi_cmd_sender`

## Requirements
- R1: After reset, msgValid is 0 and reads of both command words return 0.
- R2: A write at byte offset 0x310 stores bits 31:24 as the destination identifier. A read there returns that byte in bits 31:24 and zeros elsewhere.
- R3: A write at byte offset 0x300 while no message is pending stores the command fields and sets msgValid on the next cycle. The message outputs are: vector = bits 7:0, mode = bits 10:8 (0 fixed, 5 INIT, 6 STARTUP, where a STARTUP vector is the start page number), level = bit 14, trigger = bit 15, shorthand = bits 19:18. The destination is the identifier that was stored when the command write happened.
- R4: A read at 0x300 returns the stored command fields at their write positions, with the live pending flag (equal to msgValid) at bit 12 and every other bit at 0.
- R5: While msgValid is 1 and msgReady is 0, msgValid stays 1 and every message output holds its value. After a cycle in which msgValid and msgReady are both 1, msgValid is 0.
- R6: A write at 0x300 while a message is pending is ignored. The message outputs and the read-back fields keep their previous values.
- R7: A write at 0x310 while a message is pending updates the read-back identifier but not msgDest.
- R8: With shorthand 2'b10 (send to all, including the sender), msgDest is 8'hFF whatever the stored identifier. With any other shorthand, msgDest carries the stored identifier.
- R9: Writes to any other offset change nothing, and reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte offset for read and write |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| msgValid | output | 1 | Outbound message valid |
| msgReady | input | 1 | Outbound message accepted |
| msgDest | output | 8 | Destination identifier, all ones for broadcast |
| msgMode | output | 3 | Delivery mode |
| msgVector | output | 8 | Vector or start page number |
| msgLevel | output | 1 | Assert (1) or deassert (0) |
| msgTrigger | output | 1 | Level (1) or edge (0) triggered |
| msgShorthand | output | 2 | Destination shorthand |

## Verification
A stuck or early-clearing pending flag shows up straight away in two places: bit 12 of the command read-back, and msgValid on the cycle after the write or the handshake. A pending state that loses track of itself would let a second command overwrite the message in flight, and the field outputs would change while msgValid is high and msgReady is low. A destination taken at the wrong moment only becomes visible when the destination word is rewritten during a pending message, so the bench rewrites it on purpose and then compares msgDest with the earlier value.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic readLo;
    logic readHi;
  } ipiStrobes_t;

  typedef struct packed {
    logic [1:0] shorthand;
    logic       trigger;
    logic       level;
    logic [2:0] mode;
    logic [7:0] vector;
  } ipiCmd_t;

  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int BUSY_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;
  localparam logic [1:0] SH_ALL = 2'b10;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFF = 12'h310
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              msgReady,
  output ipiStrobes_t       strb,
  output logic              busy
);
  logic hitLo, hitHi;

  assign hitLo = (busAddr == LO_OFF);
  assign hitHi = (busAddr == HI_OFF);

  always_comb begin
    strb.readLo = hitLo;
    strb.readHi = hitHi;
    strb.loadHi = busWrEn && hitHi;
    strb.loadLo = busWrEn && hitLo && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else if (strb.loadLo) busy <= 1'b1;
    else if (busy && msgReady) busy <= 1'b0;
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipiStrobes_t       strb,
  input  logic              busy,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output ipiCmd_t           cmd,
  output logic [DEST_W-1:0] dest
);
  logic [DEST_W-1:0] hiDest;
  logic [DEST_W-1:0] pendDest;
  ipiCmd_t           wrCmd;

  always_comb begin
    wrCmd.vector    = busWrData[VEC_LSB +: 8];
    wrCmd.mode      = busWrData[MODE_LSB +: 3];
    wrCmd.level     = busWrData[LEVEL_BIT];
    wrCmd.trigger   = busWrData[TRIG_BIT];
    wrCmd.shorthand = busWrData[SH_LSB +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd      <= '0;
      hiDest   <= '0;
      pendDest <= '0;
    end else begin
      if (strb.loadHi) hiDest <= busWrData[DEST_LSB +: DEST_W];
      if (strb.loadLo) begin
        cmd      <= wrCmd;
        pendDest <= hiDest;
      end
    end
  end

  assign dest = (cmd.shorthand == SH_ALL) ? {DEST_W{1'b1}} : pendDest;

  always_comb begin
    busRdData = '0;
    if (strb.readLo) begin
      busRdData[VEC_LSB +: 8]  = cmd.vector;
      busRdData[MODE_LSB +: 3] = cmd.mode;
      busRdData[BUSY_BIT]      = busy;
      busRdData[LEVEL_BIT]     = cmd.level;
      busRdData[TRIG_BIT]      = cmd.trigger;
      busRdData[SH_LSB +: 2]   = cmd.shorthand;
    end else if (strb.readHi) begin
      busRdData[DEST_LSB +: DEST_W] = hiDest;
    end
  end
endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEST_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFF = 12'h310
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [DEST_W-1:0] msgDest,
  output logic [2:0]        msgMode,
  output logic [7:0]        msgVector,
  output logic              msgLevel,
  output logic              msgTrigger,
  output logic [1:0]        msgShorthand
);
  ipiStrobes_t strb;
  ipiCmd_t     cmd;
  logic        busy;

  ipi_ctrl #(.ADDR_W(ADDR_W), .LO_OFF(LO_OFF), .HI_OFF(HI_OFF)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .msgReady(msgReady), .strb(strb), .busy(busy)
  );

  ipi_datapath #(.DATA_W(DATA_W), .DEST_W(DEST_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .busWrData(busWrData),
    .busRdData(busRdData), .cmd(cmd), .dest(msgDest)
  );

  assign msgValid     = busy;
  assign msgMode      = cmd.mode;
  assign msgVector    = cmd.vector;
  assign msgLevel     = cmd.level;
  assign msgTrigger   = cmd.trigger;
  assign msgShorthand = cmd.shorthand;
endmodule

// File: rtl/ipi_cmd_sender_chk.sv
module ipi_cmd_sender_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEST_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 12'h300
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              msgValid,
  input logic              msgReady,
  input logic [DEST_W-1:0] msgDest,
  input logic [2:0]        msgMode,
  input logic [7:0]        msgVector,
  input logic              msgLevel,
  input logic              msgTrigger,
  input logic [1:0]        msgShorthand
);
  // R3
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!msgValid && busWrEn && busAddr == LO_OFF) |=> msgValid);

  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> msgValid);

  // R5
  msg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=>
      $stable({msgDest, msgMode, msgVector, msgLevel, msgTrigger, msgShorthand}));

  // R5
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgValid);

  // R4
  status_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == LO_OFF) |-> (busRdData[12] == msgValid));

  // R8
  bcast_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShorthand == 2'b10) |-> (msgDest == {DEST_W{1'b1}}));
endmodule

bind ipi_cmd_sender ipi_cmd_sender_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEST_W(DEST_W), .LO_OFF(LO_OFF)
) chk_i (.*);

// File: tb/ipi_cmd_sender_tb_top.sv
`timescale 1ns/1ps
module ipi_cmd_sender_tb_top;
  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;
  localparam logic [31:0] LO_MASK = 32'h000C_C7FF;
  localparam logic [31:0] HI_MASK = 32'hFF00_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [7:0]  msgDest;
  logic [2:0]  msgMode;
  logic [7:0]  msgVector;
  logic        msgLevel;
  logic        msgTrigger;
  logic [1:0]  msgShorthand;

  int errors = 0;
  int checks = 0;
  logic [31:0] mLo = '0, mHi = '0, mPend = '0;
  logic        mBusy = 1'b0;

  always #4 clk = ~clk;

  ipi_cmd_sender dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [11:0] a);
    if (a == LO) return (mLo & LO_MASK) | (32'(mBusy) << 12);
    if (a == HI) return mHi & HI_MASK;
    return 32'h0;
  endfunction

  function automatic logic [7:0] expDest();
    return (mLo[19:18] == 2'b10) ? 8'hFF : mPend[31:24];
  endfunction

  task automatic checkMsg();
    chk("R5 valid", {31'b0, msgValid}, {31'b0, mBusy});
    if (mBusy) begin
      chk("R3 fields", {msgVector, 5'b0, msgMode, msgLevel, msgTrigger, msgShorthand, 12'b0},
          {mLo[7:0], 5'b0, mLo[10:8], mLo[14], mLo[15], mLo[19:18], 12'b0});
      chk("R8 dest", {24'b0, msgDest}, {24'b0, expDest()});
    end
  endtask

  // One cycle: drive at negedge, check read, update model, check after edge.
  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d, input logic rdy);
    logic acc, hs;
    busWrEn = we; busAddr = a; busWrData = d; msgReady = rdy;
    #1;
    chk((a == LO) ? "R4 lo read" : (a == HI) ? "R2 hi read" : "R9 other read",
        busRdData, expRead(a));
    hs  = mBusy && rdy;
    acc = we && (a == LO) && !mBusy;
    if (acc) begin
      mLo = d & LO_MASK; mPend = mHi; mBusy = 1'b1;
    end else if (hs) mBusy = 1'b0;
    if (we && a == HI) mHi = d & HI_MASK;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
    checkMsg();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 valid", {31'b0, msgValid}, 32'h0);
    busAddr = LO; #1; chk("R1 lo read", busRdData, 32'h0);
    busAddr = HI; #1; chk("R1 hi read", busRdData, 32'h0);
    @(negedge clk);

    // Directed: INIT level assert to unit 0x5A, held off by ready
    step(1'b1, HI, 32'h5A00_1234, 1'b0);
    step(1'b1, LO, 32'h0000_C500, 1'b0);
    step(1'b0, LO, 32'h0, 1'b0);
    // R6: command write while pending is dropped
    step(1'b1, LO, 32'h0008_0677, 1'b0);
    chk("R6 vector kept", {24'b0, msgVector}, 32'h0);
    chk("R6 mode kept", {29'b0, msgMode}, 32'd5);
    // R7: destination rewrite while pending
    step(1'b1, HI, 32'h3300_0000, 1'b0);
    chk("R7 pending dest", {24'b0, msgDest}, 32'h5A);
    busAddr = HI; #1; chk("R7 hi readback", busRdData, 32'h3300_0000);
    // R9: write elsewhere ignored
    step(1'b1, 12'h080, 32'hFFFF_FFFF, 1'b0);
    step(1'b0, LO, 32'h0, 1'b1);
    chk("R5 cleared", {31'b0, msgValid}, 32'h0);
    // R8: broadcast STARTUP with page 0x9F
    step(1'b1, LO, 32'h0008_069F, 1'b0);
    chk("R8 broadcast dest", {24'b0, msgDest}, 32'hFF);
    chk("R3 startup page", {24'b0, msgVector}, 32'h9F);
    step(1'b0, LO, 32'h0, 1'b1);
    // R3: fixed mode, edge, deassert, no shorthand
    step(1'b1, LO, 32'h0000_0041, 1'b0);
    chk("R3 dest from hi", {24'b0, msgDest}, 32'h33);
    step(1'b0, HI, 32'h0, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      int unsigned op = $urandom % 8;
      logic [31:0] d = $urandom;
      logic rdy = ($urandom % 3) == 0;
      logic [11:0] ra;
      case ($urandom % 3)
        0: ra = LO;
        1: ra = HI;
        default: ra = 12'h3F0;
      endcase
      if (op < 3) begin
        d[10:8] = (op == 0) ? 3'd0 : (op == 1) ? 3'd5 : 3'd6;
        step(1'b1, LO, d, rdy);
      end else if (op == 3) step(1'b1, HI, d, rdy);
      else if (op == 4) step(1'b1, 12'h320, d, rdy);
      else step(1'b0, ra, 32'h0, rdy);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule